// File: doc/BRIEF.md
# Selectable-Window Pin Noise Filter

This block cleans up one external input pin before the logic that consumes it. The pin is brought into the clock domain through a two-flop synchronizer. A new level is then passed to the filtered output only after the synchronized input has disagreed with the current output for enough consecutive instruction-cycle ticks. The time constant of the filter is chosen by a 2-bit select: 1, 32 or 128 instruction cycles. A pulse is guaranteed to get through when it lasts twice the time constant, which is 2, 64 or 256 ticks.

The filtered level drives an interrupt source, a timer event input and a timer capture input that share the pin. These consumers receive a one-clock strobe on each filtered rising edge and each filtered falling edge. Software port reads do not use the filter: they read the synchronized raw level, whatever window is selected. The reset is asynchronous and active low, and the block releases it synchronously on its own.

Top module: `pin_noise_filter`

## Requirements
- R1: While reset is held, `level_out` and `raw_level` are 1, and `rise_pulse` and `fall_pulse` are 0.
- R2: Out of reset, `raw_level` equals the value `pin_async` had two clock edges earlier.
- R3: With `win_sel` = 0 (time constant 1), a new level reaches `level_out` after 2 consecutive ticks of disagreement. One tick is not enough.
- R4: With `win_sel` = 1 (time constant 32), a new level is accepted after 64 consecutive disagreeing ticks. A run of 63 is rejected.
- R5: With `win_sel` = 2 or 3 (time constant 128), a new level is accepted after 256 consecutive disagreeing ticks. A run of 255 is rejected.
- R6: Any clock in which the synchronized input equals `level_out` clears the stability count, so interrupted runs do not add up.
- R7: A clock in which `win_sel` differs from its value on the previous clock clears the stability count, and `level_out` does not change in that clock.
- R8: Clocks in which `tick` is 0 do not advance the stability count and never change `level_out`.
- R9: `rise_pulse` is high for exactly one clock when `level_out` goes 0 to 1, and `fall_pulse` for one clock when it goes 1 to 0. The two are never high together.
- R10: `raw_level` shows every pin pulse at full length, whatever `win_sel` is, including pulses that the filter rejects.
- R11: After `rst_n` rises, the block stays in reset for two more clock edges. The first pin sample is taken at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Instruction-cycle enable; one tick advances the stability count |
| pin_async | input | 1 | Raw, unsynchronized pin level |
| win_sel | input | 2 | Filter time constant: 0 gives 1 cycle, 1 gives 32, 2 and 3 give 128 |
| level_out | output | 1 | Filtered pin level |
| rise_pulse | output | 1 | One-clock strobe on a filtered rising edge, for interrupt, event and capture logic |
| fall_pulse | output | 1 | One-clock strobe on a filtered falling edge, for interrupt, event and capture logic |
| raw_level | output | 1 | Synchronized but unfiltered pin level, for port reads |

## Verification
The bench builds the block with its default parameters: time constants of 1, 32 and 128, and two synchronizer stages. With these values, the exact accept and reject thresholds of all three windows (2, 64 and 256 ticks) take only a few hundred clocks each. The pulse lengths sit one tick on each side of every threshold. With the short window and a sparse tick pattern, the gating by tick is visible within a handful of clocks. The bench also restarts a long run by briefly switching the select, and it breaks a long run with one matching clock. Both runs total more than the mid window but must still be rejected.

// File: rtl/nf_pkg.sv
package nf_pkg;

  typedef enum logic [1:0] {
    NF_WIN_SHORT    = 2'd0,
    NF_WIN_MID      = 2'd1,
    NF_WIN_LONG     = 2'd2,
    NF_WIN_LONG_ALT = 2'd3
  } nf_win_e;

  // A pulse is guaranteed to pass when it lasts twice the time constant.
  function automatic int unsigned nf_accept_len(input int unsigned tc);
    return 2 * tc;
  endfunction

endpackage

// File: rtl/nf_sync_chain.sv
module nf_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign chain_d[g] = din;
    end else begin : g_next
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/nf_stability.sv
module nf_stability
  import nf_pkg::*;
#(
  parameter int unsigned TC_SHORT = 1,
  parameter int unsigned TC_MID   = 32,
  parameter int unsigned TC_LONG  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sync_in,
  input  logic [1:0] win_sel,
  output logic       filt_out
);

  localparam int unsigned LONG_LEN = nf_accept_len(TC_LONG);
  localparam int          CNT_W    = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(nf_accept_len(TC_SHORT));
  localparam logic [CNT_W-1:0] LEN_MID   = CNT_W'(nf_accept_len(TC_MID));
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, need;
  logic             filt_q, filt_d;
  logic [1:0]       sel_q;
  logic             sel_chg, mismatch;

  // window decode
  always_comb begin
    unique case (nf_win_e'(win_sel))
      NF_WIN_SHORT: need = LEN_SHORT;
      NF_WIN_MID:   need = LEN_MID;
      default:      need = LEN_LONG;
    endcase
  end

  assign sel_chg  = (win_sel != sel_q);
  assign mismatch = (sync_in != filt_q);
  assign cnt_inc  = cnt_q + CNT_W'(1);

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (sel_chg || !mismatch) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= need) begin
        filt_d = sync_in;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
      sel_q  <= 2'd0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
      sel_q  <= win_sel;
    end
  end

  assign filt_out = filt_q;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LEN_LONG);

  assert_match_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in == filt_q) |=> (cnt_q == '0));

  assert_sel_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel != sel_q) |=> ((cnt_q == '0) && $stable(filt_q)));

  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt_q));

endmodule

// File: rtl/nf_edge_strobe.sv
module nf_edge_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
    end else begin
      lvl_q <= lvl;
    end
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TC_SHORT    = 1,
  parameter int unsigned TC_MID      = 32,
  parameter int unsigned TC_LONG     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pin_async,
  input  logic [1:0] win_sel,
  output logic       level_out,
  output logic       rise_pulse,
  output logic       fall_pulse,
  output logic       raw_level
);

  logic rst_sync_n;
  logic pin_sync;

  // R11: assert asynchronously, release after two edges
  nf_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_sync_n)
  );

  // R2: pin synchronizer, idles high
  nf_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (pin_async),
    .dout (pin_sync)
  );

  nf_stability #(
    .TC_SHORT(TC_SHORT),
    .TC_MID  (TC_MID),
    .TC_LONG (TC_LONG)
  ) u_stab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .sync_in (pin_sync),
    .win_sel (win_sel),
    .filt_out(level_out)
  );

  nf_edge_strobe u_edge (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .lvl  (level_out),
    .rise (rise_pulse),
    .fall (fall_pulse)
  );

  assign raw_level = pin_sync;

endmodule

// File: tb/pin_noise_filter_tb.sv
`timescale 1ns/1ps
module pin_noise_filter_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, tick, pin;
  logic [1:0] sel;
  logic       level_out, rise_pulse, fall_pulse, raw_level;

  int checks = 0, fails = 0;
  int rise_seen = 0, fall_seen = 0, raw_low_cnt = 0;
  int exp_f = 0, exp_r = 0;
  bit done = 1'b0;

  // reference model state
  bit m_rs1 = 0, m_rs2 = 0, m_s1 = 1, m_s2 = 1, m_filt = 1, m_filtd = 1;
  bit [1:0] m_selq = 0;
  int m_cnt = 0;

  pin_noise_filter u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_async(pin), .win_sel(sel),
    .level_out(level_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
    .raw_level(raw_level)
  );

  function automatic int need_of(bit [1:0] s);
    if (s == 2'd0) return 2;
    if (s == 2'd1) return 64;
    return 256;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int  ncnt;
    bit  nfilt;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = 1; m_s2 = 1;
      m_filt = 1; m_filtd = 1; m_selq = 0; m_cnt = 0;
    end else begin
      if (m_rs2) begin
        ncnt  = m_cnt;
        nfilt = m_filt;
        if (sel != m_selq || m_s2 == m_filt) ncnt = 0;
        else if (tick) begin
          if (m_cnt + 1 >= need_of(sel)) begin
            nfilt = m_s2;
            ncnt  = 0;
          end else ncnt = m_cnt + 1;
        end
        m_filtd = m_filt;
        m_filt  = nfilt;
        m_cnt   = ncnt;
        m_selq  = sel;
        m_s2    = m_s1;
        m_s1    = pin;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(level_out == m_filt, "R6 level_out vs model", level_out, m_filt);
      check(raw_level == m_s2, "R2 raw_level vs model", raw_level, m_s2);
      check(rise_pulse == (m_filt & ~m_filtd), "R9 rise_pulse vs model",
            rise_pulse, m_filt & ~m_filtd);
      check(fall_pulse == (~m_filt & m_filtd), "R9 fall_pulse vs model",
            fall_pulse, ~m_filt & m_filtd);
      rise_seen += int'(rise_pulse);
      fall_seen += int'(fall_pulse);
      if (!raw_level) raw_low_cnt++;
    end
  end

  task automatic pulse_low(int len, int settle);
    pin = 1'b0;
    repeat (len) @(negedge clk);
    pin = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic edges(string tag);
    check(fall_seen == exp_f, {tag, " falling strobes"}, fall_seen, exp_f);
    check(rise_seen == exp_r, {tag, " rising strobes"}, rise_seen, exp_r);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; pin = 1'b0; sel = 2'd0;
    repeat (3) @(negedge clk);
    check(level_out == 1'b1, "R1 level in reset", level_out, 1);
    check(raw_level == 1'b1, "R1 raw in reset", raw_level, 1);
    check(!rise_pulse && !fall_pulse, "R1 strobes in reset",
          rise_pulse | fall_pulse, 0);

    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(raw_level == 1'b1, "R11 still held after two edges", raw_level, 1);
    @(negedge clk);
    check(raw_level == 1'b0, "R11 first sample visible", raw_level, 0);
    repeat (4) @(negedge clk);
    check(level_out == 1'b0, "R3 low accepted after release", level_out, 0);
    pin = 1'b1;
    repeat (8) @(negedge clk);
    rise_seen = 0; fall_seen = 0;

    // R3: time constant 1
    pulse_low(1, 8);
    edges("R3 one-tick glitch rejected");
    pulse_low(2, 8);
    exp_f++; exp_r++;
    edges("R3 two-tick pulse accepted");

    // R4: time constant 32
    sel = 2'd1;
    pulse_low(63, 10);
    edges("R4 63-tick pulse rejected");
    pulse_low(64, 80);
    exp_f++; exp_r++;
    edges("R4 64-tick pulse accepted");

    // R5 and R10: time constant 128, both select codes
    sel = 2'd2;
    raw_low_cnt = 0;
    pulse_low(255, 10);
    check(raw_low_cnt == 255, "R10 raw shows rejected pulse", raw_low_cnt, 255);
    edges("R5 255-tick pulse rejected (code 2)");
    pulse_low(256, 270);
    exp_f++; exp_r++;
    edges("R5 256-tick pulse accepted (code 2)");
    sel = 2'd3;
    pulse_low(255, 10);
    edges("R5 255-tick pulse rejected (code 3)");
    pulse_low(256, 270);
    exp_f++; exp_r++;
    edges("R5 256-tick pulse accepted (code 3)");

    // R6: an interrupted run does not accumulate
    sel = 2'd1;
    repeat (4) @(negedge clk);
    pin = 1'b0; repeat (40) @(negedge clk);
    pin = 1'b1; @(negedge clk);
    pin = 1'b0; repeat (40) @(negedge clk);
    pin = 1'b1; repeat (10) @(negedge clk);
    edges("R6 broken run rejected");

    // R7: select change restarts the count
    pin = 1'b0; repeat (40) @(negedge clk);
    sel = 2'd2; @(negedge clk);
    sel = 2'd1; repeat (60) @(negedge clk);
    pin = 1'b1; repeat (10) @(negedge clk);
    edges("R7 restarted run rejected");

    // R8: no tick, no progress
    sel = 2'd0;
    repeat (3) @(negedge clk);
    tick = 1'b0; pin = 1'b0;
    repeat (10) @(negedge clk);
    check(level_out == 1'b1, "R8 held without ticks", level_out, 1);
    tick = 1'b1; @(negedge clk);
    tick = 1'b0; repeat (5) @(negedge clk);
    check(level_out == 1'b1, "R8 one tick not enough", level_out, 1);
    tick = 1'b1; @(negedge clk);
    tick = 1'b0; repeat (2) @(negedge clk);
    check(level_out == 1'b0, "R8 second tick accepts", level_out, 0);
    tick = 1'b1; pin = 1'b1;
    repeat (10) @(negedge clk);
    exp_f++; exp_r++;
    edges("R8 sparse ticks");
    check(level_out == 1'b1, "R9 final level", level_out, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule